// File: doc/BRIEF.md
# Gold Code Chip Generator

This block produces a spreading code at chip rate by combining two five-stage maximal-length shift registers. Both registers step together on a chip-enable strobe, which the surrounding logic pulses at the system chip rate of 1.2288 Mchip/s. The output chip is the exclusive-OR of the two registers' low-order bits. The two feedback polynomials form a preferred pair, so every code the block can emit belongs to one family. Within that family the periodic cross-correlation between any two members, at any lag, never exceeds 9 in magnitude.

A node picks its code by loading seeds into the two registers. The seed of the second register sets its phase relative to the first, and that phase offset selects the family member. A one-chip marker flags the start of every 31-chip code period, so framing logic can align symbols to the code.

Top module: `gold_chip_gen`

## Requirements
- R1: On synchronous reset both registers take the seed 00001, so in the first cycle after reset `chip_o` is 0 and `period_start_o` is 1.
- R2: Seed bit i of the first register is sequence term a[i], and that register generates a[k+5] = a[k+2] xor a[k] (polynomial x^5+x^2+1).
- R3: Seed bit i of the second register is term b[i], and that register generates b[k+5] = b[k+4] xor b[k+3] xor b[k+2] xor b[k] (polynomial x^5+x^4+x^3+x^2+1).
- R4: After k chip enables since the last load or reset, `chip_o` equals a[k mod 31] xor b[k mod 31].
- R5: With `chip_en_i` low and `load_i` low, neither register advances, and `chip_o` and `period_start_o` keep their values.
- R6: A load copies both seeds in one clock, and an all-zero seed is replaced by 00001.
- R7: A load takes priority over a chip enable in the same cycle. In the cycle after the load, k = 0.
- R8: `period_start_o` is high exactly when the first register holds its loaded seed, which is when k mod 31 = 0.
- R9: The chip sequence repeats every 31 enables, and both registers return to their seeds in the same cycle.
- R10: Two codes built from the same first seed and different non-zero second seeds have a periodic cross-correlation of magnitude at most 9 at every lag, counting a chip of 1 as +1 and a chip of 0 as -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| chip_en_i | input | 1 | Chip-rate strobe; each pulse advances the code by one chip |
| load_i | input | 1 | Loads both seeds in one clock |
| seed_a_i | input | 5 | Seed for the first register |
| seed_b_i | input | 5 | Seed for the second register, which selects the family member |
| chip_o | output | 1 | Current code chip |
| period_start_o | output | 1 | High on the first chip of each code period |

## Verification
On every cycle the assertions check:
- the shift step of each register;
- that a register holds while idle;
- the result of a load, including the zero-seed substitution;
- that neither register can reach the all-zero state;
- that the period marker appears after exactly 31 enables;
- that the two registers return to their seeds in the same cycle.

Only the bench's scenarios can show that the bit streams follow the stated recurrences and that the XOR of the two streams is correct. The bench checks this against sequences it builds from the seeds. It also collects whole code periods for several second-register seeds and measures their cross-correlation at every lag, because the family bound is a property of complete periods.

// File: rtl/gold_pkg.sv
package gold_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_RESET = 2'd3
   } gold_act_e;
endpackage

// File: rtl/gold_ctrl.sv
module gold_ctrl
   import gold_pkg::*;
(
   input  logic      rst_i,
   input  logic      load_i,
   input  logic      chip_en_i,
   output gold_act_e act_o
);
   // Reset outranks load, and load outranks a chip step.
   always_comb begin
      if (rst_i)          act_o = ACT_RESET;
      else if (load_i)    act_o = ACT_LOAD;
      else if (chip_en_i) act_o = ACT_STEP;
      else                act_o = ACT_HOLD;
   end
endmodule

// File: rtl/gold_lfsr.sv
module gold_lfsr
   import gold_pkg::*;
#(
   parameter int                 STAGES     = 5,
   parameter logic [STAGES-1:0]  TAP_MASK   = 5'b00101,
   parameter logic [STAGES-1:0]  RESET_SEED = 5'b00001
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  gold_act_e         act_i,
   input  logic [STAGES-1:0] seed_i,
   output logic              lead_o,
   output logic              at_seed_o
);
   localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

   generate
      if (TAP_MASK[0] != 1'b1) begin : g_bad_mask
         $error("gold_lfsr: tap mask must include the lowest term");
      end
      if (RESET_SEED == '0) begin : g_bad_seed
         $error("gold_lfsr: reset seed must be non-zero");
      end
   endgenerate

   logic [STAGES-1:0] state_q, seed_q, seed_clean;
   logic              fb;

   assign seed_clean = (seed_i == '0) ? ONE : seed_i;
   assign fb         = ^(state_q & TAP_MASK);

   always_ff @(posedge clk_i) begin
      unique case (act_i)
         ACT_RESET: begin
            state_q <= RESET_SEED;
            seed_q  <= RESET_SEED;
         end
         ACT_LOAD: begin
            state_q <= seed_clean;
            seed_q  <= seed_clean;
         end
         ACT_STEP: state_q <= {fb, state_q[STAGES-1:1]};
         default:  state_q <= state_q;
      endcase
   end

   assign lead_o    = state_q[0];
   assign at_seed_o = (state_q == seed_q);

   // R6
   nonzero_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q != '0);

   // R5
   hold_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      act_i == ACT_HOLD |=> $stable(state_q));

   // R2
   shift_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      act_i == ACT_STEP |=> state_q[STAGES-2:0] == $past(state_q[STAGES-1:1]));

   // R6
   load_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      act_i == ACT_LOAD |=> state_q == (($past(seed_i) == '0) ? ONE : $past(seed_i)));
endmodule

// File: rtl/gold_chip_gen.sv
module gold_chip_gen
   import gold_pkg::*;
#(
   parameter int                STAGES       = 5,
   parameter logic [STAGES-1:0] TAP_MASK_A   = 5'b00101,
   parameter logic [STAGES-1:0] TAP_MASK_B   = 5'b11101,
   parameter logic [STAGES-1:0] RESET_SEED_A = 5'b00001,
   parameter logic [STAGES-1:0] RESET_SEED_B = 5'b00001
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              chip_en_i,
   input  logic              load_i,
   input  logic [STAGES-1:0] seed_a_i,
   input  logic [STAGES-1:0] seed_b_i,
   output logic              chip_o,
   output logic              period_start_o
);
   localparam int NREG   = 2;
   localparam int PERIOD = (1 << STAGES) - 1;
   localparam int CW     = $clog2(PERIOD + 1);

   localparam logic [NREG-1:0][STAGES-1:0] MASKS  = {TAP_MASK_B, TAP_MASK_A};
   localparam logic [NREG-1:0][STAGES-1:0] RSEEDS = {RESET_SEED_B, RESET_SEED_A};

   generate
      if (STAGES < 3) begin : g_short
         $error("gold_chip_gen: at least three stages required");
      end
      if (STAGES % 4 == 0) begin : g_no_pair
         $error("gold_chip_gen: no preferred pair exists when STAGES is a multiple of 4");
      end
   endgenerate

   gold_act_e                     act;
   logic [NREG-1:0][STAGES-1:0]   seeds;
   logic [NREG-1:0]               lead, at_seed;

   assign seeds = {seed_b_i, seed_a_i};

   gold_ctrl u_ctrl (
      .rst_i     (rst_i),
      .load_i    (load_i),
      .chip_en_i (chip_en_i),
      .act_o     (act)
   );

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         gold_lfsr #(
            .STAGES     (STAGES),
            .TAP_MASK   (MASKS[g]),
            .RESET_SEED (RSEEDS[g])
         ) u_lfsr (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .act_i     (act),
            .seed_i    (seeds[g]),
            .lead_o    (lead[g]),
            .at_seed_o (at_seed[g])
         );
      end
   endgenerate

   assign chip_o         = ^lead;
   assign period_start_o = at_seed[0];

   // Enables counted since the last period start, kept only for the checks.
   logic [CW-1:0] since_q;
   always_ff @(posedge clk_i) begin
      if (rst_i || load_i)   since_q <= '0;
      else if (chip_en_i)    since_q <= (since_q == CW'(PERIOD - 1)) ? '0 : since_q + 1'b1;
   end

   // R9
   period_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (chip_en_i && !load_i && since_q == CW'(PERIOD - 1)) |=> period_start_o);

   // R8
   early_mark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (chip_en_i && !load_i && since_q != CW'(PERIOD - 1)) |=> !period_start_o);

   // R9
   joint_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      at_seed[0] == at_seed[1]);
endmodule

// File: tb/sim_gold_chip_gen.sv
module sim_gold_chip_gen;
   localparam int N   = 5;
   localparam int PER = 31;

   logic clk = 1'b0;
   logic rst, en, ld;
   logic [N-1:0] sa, sb;
   logic chip, pstart;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   bit [PER-1:0] ma, mb;
   int k;

   always #5 clk = ~clk;

   gold_chip_gen u0 (
      .clk_i(clk), .rst_i(rst), .chip_en_i(en), .load_i(ld),
      .seed_a_i(sa), .seed_b_i(sb), .chip_o(chip), .period_start_o(pstart)
   );

   function automatic bit [PER-1:0] build_seq(bit [N-1:0] seed, bit [N-1:0] mask);
      bit [PER+N-1:0] t;
      t = '0;
      for (int i = 0; i < N; i++) t[i] = seed[i];
      for (int j = 0; j < PER; j++) begin
         bit f;
         f = 0;
         for (int i = 0; i < N; i++) if (mask[i]) f ^= t[j+i];
         t[j+N] = f;
      end
      return t[PER-1:0];
   endfunction

   function automatic bit [N-1:0] clean(bit [N-1:0] s);
      return (s == '0) ? 5'b00001 : s;
   endfunction

   task automatic check(input int act, input int expv, input string req);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, expv, k);
      end
   endtask

   task automatic check_out(input string req);
      check(chip, ma[k % PER] ^ mb[k % PER], req);
      check(pstart, (k % PER) == 0, req);
   endtask

   // Called at a falling edge: apply inputs, cross the rising edge, update model.
   task automatic tick(input bit r, input bit e, input bit l, input bit [N-1:0] a, input bit [N-1:0] b);
      rst = r; en = e; ld = l; sa = a; sb = b;
      @(posedge clk);
      @(negedge clk);
      if (r) begin
         ma = build_seq(5'b00001, 5'b00101);
         mb = build_seq(5'b00001, 5'b11101);
         k = 0;
      end else if (l) begin
         ma = build_seq(clean(a), 5'b00101);
         mb = build_seq(clean(b), 5'b11101);
         k = 0;
      end else if (e) k++;
   endtask

   bit [PER-1:0] fam [0:3];
   bit [N-1:0]   bseeds [0:3];

   initial begin
      int r;
      rst = 1; en = 0; ld = 0; sa = '0; sb = '0;
      r = $urandom(32'h6A11);
      @(negedge clk);
      tick(1, 0, 0, 0, 0);
      tick(1, 1, 1, 5'h1F, 5'h1F);
      // R1 reset state
      check(chip, 0, "R1");
      check(pstart, 1, "R1");

      // R2 R3 R4 R8 R9: continuous stepping from reset seeds across two periods
      for (int i = 0; i < 70; i++) begin
         tick(0, 1, 0, 0, 0);
         check_out("R4");
      end

      // R5 random enable pattern, outputs held while idle
      for (int i = 0; i < 100; i++) begin
         bit pc, pp, e;
         pc = chip; pp = pstart;
         e = $urandom_range(0, 1);
         tick(0, e, 0, 0, 0);
         if (!e) begin
            check(chip, pc, "R5");
            check(pstart, pp, "R5");
         end else check_out("R5");
      end

      // R6 all-zero seeds replaced by 00001
      tick(0, 0, 1, 5'b00000, 5'b00000);
      check_out("R6");
      for (int i = 0; i < 40; i++) begin
         tick(0, 1, 0, 0, 0);
         check_out("R6");
      end

      // R7 load together with enable: load wins, k restarts at 0
      tick(0, 1, 0, 0, 0);
      tick(0, 1, 1, 5'b10110, 5'b01011);
      check(k, 0, "R7");
      check_out("R7");
      tick(0, 1, 0, 0, 0);
      check_out("R7");

      // R2 R3 random seeds and enables
      for (int t = 0; t < 20; t++) begin
         bit [N-1:0] a, b;
         a = N'($urandom());
         b = N'($urandom());
         tick(0, N'($urandom()) != 0, 1, a, b);
         check_out("R2");
         for (int i = 0; i < 40; i++) begin
            tick(0, $urandom_range(0, 3) != 0, 0, 0, 0);
            check_out("R3");
         end
      end

      // R10 family cross-correlation, R9 period repeat
      bseeds[0] = 5'b00001; bseeds[1] = 5'b00110;
      bseeds[2] = 5'b10101; bseeds[3] = 5'b11111;
      for (int m = 0; m < 4; m++) begin
         bit [PER-1:0] again;
         tick(0, 0, 1, 5'b00001, bseeds[m]);
         for (int i = 0; i < PER; i++) begin
            fam[m][i] = chip;
            tick(0, 1, 0, 0, 0);
         end
         for (int i = 0; i < PER; i++) begin
            again[i] = chip;
            tick(0, 1, 0, 0, 0);
         end
         check(again, fam[m], "R9");
      end
      for (int p = 0; p < 4; p++)
         for (int q = p + 1; q < 4; q++) begin
            int worst;
            worst = 0;
            for (int lag = 0; lag < PER; lag++) begin
               int c;
               c = 0;
               for (int i = 0; i < PER; i++)
                  c += (fam[p][i] == fam[q][(i + lag) % PER]) ? 1 : -1;
               if (c < 0) c = -c;
               if (c > worst) worst = c;
            end
            check(worst <= 9, 1, "R10");
         end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule